// File: doc/BRIEF.md
# Gate Bias Refresh Sequencer

This controller walks one module's hold capacitors so that a single shared DC source can rewrite every held gate voltage in turn. A module holds several unit cells. Each unit cell has four local demultiplexers, and each demultiplexer feeds sixteen capacitors. Exactly one demultiplexer is selected at a time, by raising one row line (the unit cell) and one column line (the demultiplexer within the cell). The gate address bus then steps through the sixteen outputs of that demultiplexer. Every module in the array follows the same address, so one pass through a module refreshes the whole array.

Each gate slot raises a sample strobe while the source settles, then drops it for one cycle before the address moves on. Each gate belongs to one of two resolution classes: a coarse barrier gate or a fine gate. Each class has its own settle count. While a qubit pulse phase is applied, the sequencer goes quiet and keeps its position. An optional period timer restarts passes on its own and flags any pass that is still running when the next one is due.

Top module: `bias_refresh_seq`

## Requirements
- R1: After reset, every row and column enable, the sample strobe, the fine flag, the done pulse and the overrun flag are low, and the gate address is 0.
- R2: A pass visits the gates in this order: unit cell 0 upward (outermost), then demultiplexer 0 to 3, then gate 0 to 15 (innermost). The gate index is driven on `gate_addr_o`. The pass makes exactly CELLS*DEMUX*GATES strobe pulses.
- R3: Gates with index GATES/2 and above are fine and drive `fine_o` high; lower indices are coarse. In each slot the strobe is high for dwell+1 cycles and then low for one cycle. The dwell is `fine_dwell_i` for a fine gate and `coarse_dwell_i` for a coarse gate.
- R4: While a pass is active and not held, `row_en_o` has exactly bit (cell index) set and `col_en_o` has exactly bit (demultiplexer index) set. At all other times both are zero.
- R5: One cycle after the last slot ends, `pass_done_o` pulses high for exactly one cycle, and the address returns to 0. With the default sizes, a pass takes 128*(coarse+fine+4) cycles, counted from the start edge to the done pulse.
- R6: A start pulse while idle begins a pass at cell 0, demultiplexer 0, gate 0. A start pulse while a pass is running does not change the pass.
- R7: While `ac_hold_i` is high, all enables and the strobe are low and the position does not change. After release, the same gate resumes with a full, fresh settle count.
- R8: Abort ends a running pass in the next cycle without a done pulse. It returns the position to the first gate and disarms the period timer.
- R9: If `period_i` is nonzero, a start arms a timer that begins a new pass every `period_i` cycles. If the period expires while a pass is still running, `overrun_o` goes high and stays high until the next start pulse or reset. If `period_i` is 0, there is no automatic restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a pass and arm the period timer |
| abort_i | input | 1 | Stop the pass and disarm the timer |
| ac_hold_i | input | 1 | Qubit pulse phase active; suspend refresh |
| coarse_dwell_i | input | DW | Settle count for coarse gates |
| fine_dwell_i | input | DW | Settle count for fine gates |
| period_i | input | PW | Auto-restart period in cycles; 0 disables it |
| row_en_o | output | CELLS | One-hot unit cell (crossbar row) select |
| col_en_o | output | DEMUX | One-hot demultiplexer (crossbar column) select |
| gate_addr_o | output | clog2(GATES) | Shared gate address bus |
| sample_o | output | 1 | Sample strobe for the shared bias source |
| fine_o | output | 1 | Current gate is in the fine class |
| pass_done_o | output | 1 | One-cycle pulse at the end of a pass |
| overrun_o | output | 1 | Sticky flag: a period expired during a pass |

## Verification
A wrong nested counter shows up at the first strobe edge where it matters. A skipped or repeated demultiplexer, or a wrong carry, puts a row, column or address on the crossbar that differs from the expected index sequence. A wrong class decode or settle compare changes the strobe width of a single slot, so the slot after it is already misaligned. A broken pass-end or timer path changes the pass length or the restart interval by whole cycles, and the change is visible when the done pulse or the next strobe arrives.

// File: rtl/bias_refresh_seq.sv
module bias_refresh_seq #(
  parameter int CELLS = 4,
  parameter int DEMUX = 4,
  parameter int GATES = 16,
  parameter int DW    = 8,
  parameter int PW    = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic                     abort_i,
  input  logic                     ac_hold_i,
  input  logic [DW-1:0]            coarse_dwell_i,
  input  logic [DW-1:0]            fine_dwell_i,
  input  logic [PW-1:0]            period_i,
  output logic [CELLS-1:0]         row_en_o,
  output logic [DEMUX-1:0]         col_en_o,
  output logic [$clog2(GATES)-1:0] gate_addr_o,
  output logic                     sample_o,
  output logic                     fine_o,
  output logic                     pass_done_o,
  output logic                     overrun_o
);
  localparam int CW = (CELLS > 1) ? $clog2(CELLS) : 1;
  localparam int XW = (DEMUX > 1) ? $clog2(DEMUX) : 1;
  localparam int GW = $clog2(GATES);

  logic          run_q, armed_q, done_q, ovr_q;
  logic [CW-1:0] cell_q;
  logic [XW-1:0] dmx_q;
  logic [GW-1:0] gate_q;
  logic [DW:0]   cnt_q;
  logic [PW-1:0] tmr_q;

  wire          fine     = (32'(gate_q) >= 32'(GATES / 2));
  wire [DW-1:0] dwell    = fine ? fine_dwell_i : coarse_dwell_i;
  wire          active   = run_q && !ac_hold_i;
  wire          slot_end = active && (cnt_q == ({1'b0, dwell} + (DW+1)'(1)));
  wire          g_last   = (32'(gate_q) == 32'(GATES - 1));
  wire          x_last   = (32'(dmx_q) == 32'(DEMUX - 1));
  wire          c_last   = (32'(cell_q) == 32'(CELLS - 1));
  wire          tick     = armed_q && (period_i != '0) && (tmr_q == period_i - PW'(1));
  wire          go       = (start_i || tick) && !run_q;

  assign row_en_o    = active ? (CELLS'(1) << cell_q) : '0;
  assign col_en_o    = active ? (DEMUX'(1) << dmx_q) : '0;
  assign sample_o    = active && (cnt_q <= {1'b0, dwell});
  assign gate_addr_o = gate_q;
  assign fine_o      = fine;
  assign pass_done_o = done_q;
  assign overrun_o   = ovr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0; armed_q <= 1'b0; done_q <= 1'b0; ovr_q <= 1'b0;
      cell_q <= '0; dmx_q <= '0; gate_q <= '0; cnt_q <= '0; tmr_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (abort_i) begin
        run_q <= 1'b0; armed_q <= 1'b0;
        cell_q <= '0; dmx_q <= '0; gate_q <= '0; cnt_q <= '0; tmr_q <= '0;
      end else begin
        if (start_i) ovr_q <= 1'b0;
        if (tick && run_q) ovr_q <= 1'b1;
        if (start_i && !run_q) begin
          armed_q <= 1'b1;
          tmr_q   <= '0;
        end else if (armed_q) begin
          tmr_q <= tick ? '0 : tmr_q + PW'(1);
        end
        if (go) begin
          run_q <= 1'b1;
          cnt_q <= '0;
        end else if (run_q) begin
          if (ac_hold_i) begin
            cnt_q <= '0;
          end else if (slot_end) begin
            cnt_q <= '0;
            if (g_last) begin
              gate_q <= '0;
              if (x_last) begin
                dmx_q <= '0;
                if (c_last) begin
                  cell_q <= '0;
                  run_q  <= 1'b0;
                  done_q <= 1'b1;
                end else begin
                  cell_q <= cell_q + CW'(1);
                end
              end else begin
                dmx_q <= dmx_q + XW'(1);
              end
            end else begin
              gate_q <= gate_q + GW'(1);
            end
          end else begin
            cnt_q <= cnt_q + (DW+1)'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/bias_refresh_seq_chk.sv
module bias_refresh_seq_chk #(
  parameter int CELLS = 4,
  parameter int DEMUX = 4,
  parameter int GATES = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     start_i,
  input logic                     abort_i,
  input logic                     ac_hold_i,
  input logic [CELLS-1:0]         row_en_o,
  input logic [DEMUX-1:0]         col_en_o,
  input logic [$clog2(GATES)-1:0] gate_addr_o,
  input logic                     sample_o,
  input logic                     pass_done_o,
  input logic                     overrun_o
);
  AST_ROW_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(row_en_o)); // R4
  AST_XBAR_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (row_en_o != '0) |-> ($countones(col_en_o) == 1)); // R4
  AST_STROBE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |-> (row_en_o != '0)); // R4
  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ac_hold_i |-> (row_en_o == '0 && col_en_o == '0 && !sample_o)); // R7
  AST_HOLD_PLACE: assert property (@(posedge clk) disable iff (!rst_n)
    (ac_hold_i && !abort_i) |=> $stable(gate_addr_o)); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pass_done_o |=> !pass_done_o); // R5
  AST_ABORT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (row_en_o == '0 && !sample_o && !pass_done_o && gate_addr_o == '0)); // R8
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun_o && !start_i) |=> overrun_o); // R9
endmodule

bind bias_refresh_seq bias_refresh_seq_chk #(.CELLS(CELLS), .DEMUX(DEMUX), .GATES(GATES)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i), .ac_hold_i(ac_hold_i),
  .row_en_o(row_en_o), .col_en_o(col_en_o), .gate_addr_o(gate_addr_o),
  .sample_o(sample_o), .pass_done_o(pass_done_o), .overrun_o(overrun_o)
);

// File: tb/bias_refresh_seq_tb.sv
`timescale 1ns/1ps
module bias_refresh_seq_tb;
  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, abort_i = 1'b0, ac_hold_i = 1'b0;
  logic [7:0]  coarse_dwell_i = '0, fine_dwell_i = '0;
  logic [15:0] period_i = '0;
  logic [3:0]  row_en_o, col_en_o, gate_addr_o;
  logic        sample_o, fine_o, pass_done_o, overrun_o;

  int tests = 0, fails = 0;
  int mon_err = 0, nrise = 0;

  always #10 clk = ~clk;

  bias_refresh_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i), .ac_hold_i(ac_hold_i),
    .coarse_dwell_i(coarse_dwell_i), .fine_dwell_i(fine_dwell_i), .period_i(period_i),
    .row_en_o(row_en_o), .col_en_o(col_en_o), .gate_addr_o(gate_addr_o),
    .sample_o(sample_o), .fine_o(fine_o), .pass_done_o(pass_done_o), .overrun_o(overrun_o)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Sequence monitor for R2, R3, R4, R7
  int  idx = 0, lastg = 0, hi = 0;
  bit  prev = 0, held = 0, curfine = 0;
  always @(negedge clk) begin
    if (!rst_n || abort_i) begin
      idx = 0; prev = 0; held = 0; hi = 0;
    end else if (ac_hold_i) begin
      if (sample_o || row_en_o != 0 || col_en_o != 0) mon_err++;
      held = 1; prev = 0; hi = 0;
    end else begin
      if (sample_o && !prev) begin
        int g;
        g = held ? lastg : idx;
        if (!held) begin idx = (idx + 1) % 256; nrise++; end
        lastg = g; held = 0; hi = 1;
        curfine = ((g % 16) >= 8);
        if (row_en_o != 4'(1 << (g / 64))) mon_err++;
        if (col_en_o != 4'(1 << ((g / 16) % 4))) mon_err++;
        if (int'(gate_addr_o) != g % 16) mon_err++;
        if (fine_o != curfine) mon_err++;
      end else if (sample_o) begin
        hi++;
      end else if (prev) begin
        if (hi != (curfine ? int'(fine_dwell_i) + 1 : int'(coarse_dwell_i) + 1)) mon_err++;
      end
      prev = sample_o;
    end
  end

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!pass_done_o) begin @(negedge clk); n++; end
  endtask

  localparam int NV = 4;
  localparam int VEC [NV][3] = '{'{0, 0, 512}, '{1, 3, 1024}, '{2, 5, 1408}, '{7, 0, 1408}};

  initial begin
    int n, e0, r0, a0, rr, cc, seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset quiet", int'({row_en_o, col_en_o, gate_addr_o, sample_o, fine_o, pass_done_o, overrun_o}), 0);

    for (int v = 0; v < NV; v++) begin
      coarse_dwell_i = 8'(VEC[v][0]); fine_dwell_i = 8'(VEC[v][1]);
      e0 = mon_err; r0 = nrise;
      pulse_start();
      wait_done(n);
      check("R5 pass length", n, VEC[v][2]);
      check("R2 strobe count", nrise - r0, 256);
      check("R2/R3/R4 order and widths", mon_err - e0, 0);
      @(negedge clk);
      check("R5 address wraps to 0", int'(gate_addr_o), 0);
    end

    coarse_dwell_i = 8'd1; fine_dwell_i = 8'd3;
    // R6 start while running is ignored
    pulse_start(); n = 0;
    repeat (300) begin @(negedge clk); n++; end
    start_i = 1'b1; @(negedge clk); n++; start_i = 1'b0;
    while (!pass_done_o) begin @(negedge clk); n++; end
    check("R6 start mid-pass ignored", n, 1024);
    @(negedge clk);

    // R8 abort mid pass
    pulse_start();
    repeat (100) @(negedge clk);
    abort_i = 1'b1; @(negedge clk); abort_i = 1'b0;
    check("R8 abort silences crossbar", int'({row_en_o, col_en_o, sample_o}), 0);
    seen = 0;
    repeat (1100) begin if (pass_done_o) seen++; @(negedge clk); end
    check("R8 no done after abort", seen, 0);
    e0 = mon_err;
    pulse_start(); wait_done(n);
    check("R8/R6 fresh pass from first gate", n, 1024);
    check("R8 order after abort", mon_err - e0, 0);
    @(negedge clk);

    // R7 hold
    e0 = mon_err;
    pulse_start();
    repeat (50) @(negedge clk);
    a0 = gate_addr_o; rr = row_en_o; cc = col_en_o;
    ac_hold_i = 1'b1; seen = 0;
    repeat (20) begin
      @(negedge clk);
      if (sample_o || row_en_o != 0 || col_en_o != 0 || int'(gate_addr_o) != a0) seen++;
    end
    check("R7 quiet and parked during hold", seen, 0);
    ac_hold_i = 1'b0;
    @(negedge clk);
    check("R7 resumes same slot", int'({row_en_o, col_en_o, gate_addr_o}), (rr << 8) | (cc << 4) | a0);
    check("R7 resumed strobe high", int'(sample_o), 1);
    wait_done(n);
    check("R7 order and settle after hold", mon_err - e0, 0);
    @(negedge clk);

    // R9 auto restart
    period_i = 16'd1100;
    pulse_start(); n = 0;
    while (!pass_done_o) begin @(negedge clk); n++; end
    while (!sample_o) begin @(negedge clk); n++; end
    check("R9 restart interval", n, 1100);
    check("R9 no overrun when period long", int'(overrun_o), 0);
    abort_i = 1'b1; @(negedge clk); abort_i = 1'b0;

    // R9 overrun
    period_i = 16'd600;
    pulse_start();
    repeat (700) @(negedge clk);
    check("R9 overrun set", int'(overrun_o), 1);
    abort_i = 1'b1; @(negedge clk); abort_i = 1'b0;
    repeat (5) @(negedge clk);
    check("R9 overrun sticky", int'(overrun_o), 1);
    period_i = 16'd0;
    pulse_start();
    check("R9 start clears overrun", int'(overrun_o), 0);
    wait_done(n);
    @(negedge clk);
    seen = 0;
    repeat (2000) begin @(negedge clk); if (sample_o) seen++; end
    check("R9 period 0 no restart", seen, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule